// File: doc/BRIEF.md
# Enclave Tracking Request Checker

This block judges a single privileged request that asks the tracking facility to begin a new tracking cycle for an enclave control page. The request brings a leaf code, the caller's privilege level and the page address. Alongside it come status inputs from neighbouring units: whether the address lies in the protected region, the page-map valid bit and page type, the page's tracking counter, a busy indication from the tracking facility, the guest and virtualization-extension mode bits, and the page's context value. The block produces exactly one outcome per accepted request. That outcome is a general-protection fault, a page fault that carries the address, a virtualization exit with reason and qualification fields, a soft error, or a success. Soft errors and successes also carry a return code and an arithmetic flag image.

Requests arrive on a valid/ready handshake. The request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` then drops for the single evaluation cycle. A requester that keeps `req_valid` high simply waits, with its fields held stable. The outcome appears as a one-cycle `res_valid` pulse in the cycle after acceptance and has no back-pressure. A request whose leaf code is not this block's leaf is consumed without any outcome.

The block also keeps a per-page exclusive lock over the tracking facility, indexed by the low page-number bits. A request that gets past the privilege, alignment, region and conflict checks takes the lock. The lock is dropped as soon as the outcome is issued, whatever that outcome is.

Top module: `trk_req_checker`

## Requirements
- R1: `req_ready` is high whenever no request is in evaluation. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low in the following cycle, and `res_valid` pulses high for exactly that one cycle.
- R2: A request whose `req_leaf` differs from 0x0C is consumed with no `res_valid` pulse and no lock taken, and `req_ready` stays high.
- R3: A privilege level other than 0 gives a general-protection fault (`res_kind` bit 2), ahead of every other check.
- R4: An address whose low 12 bits are not all zero gives a general-protection fault (`res_kind` bit 2).
- R5: An aligned address outside the protected region gives a page fault (`res_kind` bit 3) with `res_fault_addr` equal to the request address.
- R6: If the tracking facility is busy while the caller is a guest with the extension enabled, the outcome is a virtualization exit (`res_kind` bit 4). The exit has reason 0x3F, qualification 1 (resource conflict), guest-physical address equal to `st_context` and guest-linear address 0.
- R7: If the tracking facility is busy in any other mode, the outcome is a general-protection fault (`res_kind` bit 2).
- R8: A cleared page-map valid bit gives a page fault (`res_kind` bit 3) with the address. This check comes after the conflict check.
- R9: A page type other than 1 (control page) gives a page fault (`res_kind` bit 3) with the address.
- R10: If the tracking counter is nonzero outside guest-with-extension mode, the outcome is a soft error (`res_kind` bit 1) with return code 0x21 and ZF set.
- R11: If the tracking counter is nonzero in guest-with-extension mode, the outcome is a virtualization exit with qualification 2 (reference conflict). All other exit fields are as in R6.
- R12: Success (`res_kind` bit 0) returns code 0 with ZF clear. On soft error and success, `res_flags_we` is 1 and `res_flags` (bit 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF) has only ZF possibly set. On faults and exits, `res_flags_we`, `res_flags` and `res_code` are 0.
- R13: `lock_o[page bits 13:12]` is high in the outcome cycle exactly when the request passed checks R3, R4, R5 and the conflict check. It is low again in the cycle after the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_leaf | input | 8 | Leaf code of the request |
| req_cpl | input | 2 | Caller privilege level |
| req_addr | input | 32 | Control page address |
| st_in_region | input | 1 | Address lies in the protected region |
| st_map_valid | input | 1 | Page-map entry valid bit |
| st_page_type | input | 3 | Page-map page type |
| st_track | input | 8 | Page tracking counter |
| st_facility_busy | input | 1 | Another tracking operation holds the facility for this page |
| st_guest | input | 1 | Caller runs as a guest |
| st_virt_ext | input | 1 | Virtualization extension enabled |
| st_context | input | 32 | Page context value for exits |
| res_valid | output | 1 | Outcome pulse |
| res_kind | output | 5 | One-hot: 0 success, 1 soft error, 2 GP fault, 3 page fault, 4 exit |
| res_code | output | 8 | Return code |
| res_flags | output | 6 | Flag image (CF, PF, AF, ZF, SF, OF from bit 0) |
| res_flags_we | output | 1 | Flag image is to be written |
| res_fault_addr | output | 32 | Address reported by a page fault |
| res_exit_reason | output | 8 | Exit reason |
| res_exit_qual | output | 2 | Exit qualification code |
| res_exit_gpa | output | 32 | Exit guest-physical address |
| res_exit_gla | output | 32 | Exit guest-linear address |
| lock_o | output | 4 | Per-page tracking lock |

## Verification
The assertions assume that a requester offering a request keeps its status inputs consistent with that request in the accepting cycle only; the block samples everything on acceptance. They also assume `rst_n` is held low before the first edge. The bench keeps to these assumptions by driving every field together at the falling edge and lowering `req_valid` right after acceptance, except in the deliberate hold test. The sweep covers every combination of the nine check inputs, with addresses spread over all lock slots.

// File: rtl/trk_pkg.sv
package trk_pkg;
  // one-hot positions of the outcome
  localparam int KIND_N    = 5;
  localparam int KIND_OK   = 0;
  localparam int KIND_SOFT = 1;
  localparam int KIND_GP   = 2;
  localparam int KIND_PF   = 3;
  localparam int KIND_EXIT = 4;

  // flag image positions
  localparam int FLAG_N  = 6;
  localparam int FLAG_ZF = 3;

  localparam logic [1:0] QUAL_NONE      = 2'd0;
  localparam logic [1:0] QUAL_RESOURCE  = 2'd1;
  localparam logic [1:0] QUAL_REFERENCE = 2'd2;

  // predicates sampled when a request is taken
  typedef struct packed {
    logic cpl_ok;
    logic aligned;
    logic in_region;
    logic fac_busy;
    logic guest_ext;
    logic map_valid;
    logic type_ok;
    logic trk_pending;
  } trk_pred_t;
endpackage

// File: rtl/trk_req_stage.sv
module trk_req_stage
  import trk_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          LEAF_W     = 8,
  parameter int          PT_W       = 3,
  parameter int          TRK_W      = 8,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [7:0]  LEAF_CODE  = 8'h0C,
  parameter logic [2:0]  CTRL_TYPE  = 3'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LEAF_W-1:0] req_leaf,
  input  logic [1:0]        req_cpl,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              st_in_region,
  input  logic              st_map_valid,
  input  logic [PT_W-1:0]   st_page_type,
  input  logic [TRK_W-1:0]  st_track,
  input  logic              st_facility_busy,
  input  logic              st_guest,
  input  logic              st_virt_ext,
  input  logic [ADDR_W-1:0] st_context,
  output logic              ready,
  output logic              busy_q,
  output logic              start,
  output logic              take_lock,
  output trk_pred_t         pred_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] ctx_q
);
  trk_pred_t pred_d;
  logic      accept;
  logic      leaf_ok;

  assign ready   = !busy_q;
  assign accept  = req_valid && ready;
  assign leaf_ok = (req_leaf == LEAF_W'(LEAF_CODE));
  assign start   = accept && leaf_ok;

  always_comb begin
    pred_d.cpl_ok      = (req_cpl == 2'd0);
    pred_d.aligned     = (req_addr[PAGE_SHIFT-1:0] == '0);
    pred_d.in_region   = st_in_region;
    pred_d.fac_busy    = st_facility_busy;
    pred_d.guest_ext   = st_guest && st_virt_ext;
    pred_d.map_valid   = st_map_valid;
    pred_d.type_ok     = (st_page_type == PT_W'(CTRL_TYPE));
    pred_d.trk_pending = (st_track != '0);
  end

  assign take_lock = start && pred_d.cpl_ok && pred_d.aligned &&
                     pred_d.in_region && !pred_d.fac_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pred_q <= '0;
      addr_q <= '0;
      ctx_q  <= '0;
    end else begin
      busy_q <= start;
      if (start) begin
        pred_q <= pred_d;
        addr_q <= req_addr;
        ctx_q  <= st_context;
      end
    end
  end

  // R1
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R2
  leaf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !leaf_ok) |=> !busy_q);
endmodule

// File: rtl/trk_verdict.sv
module trk_verdict
  import trk_pkg::*;
#(
  parameter int         RC_W    = 8,
  parameter logic [7:0] RC_PREV = 8'h21
) (
  input  trk_pred_t         pred,
  output logic [KIND_N-1:0] kind,
  output logic [RC_W-1:0]   code,
  output logic [FLAG_N-1:0] flags,
  output logic              flags_we,
  output logic [1:0]        qual
);
  always_comb begin
    kind     = '0;
    code     = '0;
    flags    = '0;
    flags_we = 1'b0;
    qual     = QUAL_NONE;
    if (!pred.cpl_ok || !pred.aligned) begin
      kind[KIND_GP] = 1'b1;
    end else if (!pred.in_region) begin
      kind[KIND_PF] = 1'b1;
    end else if (pred.fac_busy) begin
      if (pred.guest_ext) begin
        kind[KIND_EXIT] = 1'b1;
        qual            = QUAL_RESOURCE;
      end else begin
        kind[KIND_GP] = 1'b1;
      end
    end else if (!pred.map_valid) begin
      kind[KIND_PF] = 1'b1;
    end else if (!pred.type_ok) begin
      kind[KIND_PF] = 1'b1;
    end else if (pred.trk_pending) begin
      if (pred.guest_ext) begin
        kind[KIND_EXIT] = 1'b1;
        qual            = QUAL_REFERENCE;
      end else begin
        kind[KIND_SOFT] = 1'b1;
        code            = RC_W'(RC_PREV);
        flags[FLAG_ZF]  = 1'b1;
        flags_we        = 1'b1;
      end
    end else begin
      kind[KIND_OK] = 1'b1;
      flags_we      = 1'b1;
    end
  end
endmodule

// File: rtl/trk_lock_table.sv
module trk_lock_table #(
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  output logic [SLOTS-1:0]  lock_q
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   lock_q[i] <= 1'b0;
      else if (set_en && set_slot == SLOT_W'(i))    lock_q[i] <= 1'b1;
      else if (clr_en && clr_slot == SLOT_W'(i))    lock_q[i] <= 1'b0;
    end
  end

  // R13
  lock_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_q) <= 1);
  // R13
  lock_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (lock_q != '0));
endmodule

// File: rtl/trk_req_checker.sv
module trk_req_checker
  import trk_pkg::*;
#(
  parameter int         ADDR_W      = 32,
  parameter int         LEAF_W      = 8,
  parameter int         PT_W        = 3,
  parameter int         TRK_W       = 8,
  parameter int         RC_W        = 8,
  parameter int         PAGE_SHIFT  = 12,
  parameter int         SLOTS       = 4,
  parameter logic [7:0] LEAF_CODE   = 8'h0C,
  parameter logic [2:0] CTRL_TYPE   = 3'd1,
  parameter logic [7:0] RC_PREV     = 8'h21,
  parameter logic [7:0] EXIT_REASON = 8'h3F,
  localparam int        SLOT_W      = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LEAF_W-1:0] req_leaf,
  input  logic [1:0]        req_cpl,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              st_in_region,
  input  logic              st_map_valid,
  input  logic [PT_W-1:0]   st_page_type,
  input  logic [TRK_W-1:0]  st_track,
  input  logic              st_facility_busy,
  input  logic              st_guest,
  input  logic              st_virt_ext,
  input  logic [ADDR_W-1:0] st_context,
  output logic              res_valid,
  output logic [4:0]        res_kind,
  output logic [RC_W-1:0]   res_code,
  output logic [5:0]        res_flags,
  output logic              res_flags_we,
  output logic [ADDR_W-1:0] res_fault_addr,
  output logic [7:0]        res_exit_reason,
  output logic [1:0]        res_exit_qual,
  output logic [ADDR_W-1:0] res_exit_gpa,
  output logic [ADDR_W-1:0] res_exit_gla,
  output logic [SLOTS-1:0]  lock_o
);
  logic              busy_q, start, take_lock;
  trk_pred_t         pred_q;
  logic [ADDR_W-1:0] addr_q, ctx_q;
  logic [KIND_N-1:0] kind;
  logic [RC_W-1:0]   code;
  logic [FLAG_N-1:0] flags;
  logic              flags_we;
  logic [1:0]        qual;

  trk_req_stage #(
    .ADDR_W(ADDR_W), .LEAF_W(LEAF_W), .PT_W(PT_W), .TRK_W(TRK_W),
    .PAGE_SHIFT(PAGE_SHIFT), .LEAF_CODE(LEAF_CODE), .CTRL_TYPE(CTRL_TYPE)
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_leaf(req_leaf),
    .req_cpl(req_cpl), .req_addr(req_addr), .st_in_region(st_in_region),
    .st_map_valid(st_map_valid), .st_page_type(st_page_type),
    .st_track(st_track), .st_facility_busy(st_facility_busy),
    .st_guest(st_guest), .st_virt_ext(st_virt_ext), .st_context(st_context),
    .ready(req_ready), .busy_q(busy_q), .start(start), .take_lock(take_lock),
    .pred_q(pred_q), .addr_q(addr_q), .ctx_q(ctx_q)
  );

  trk_verdict #(.RC_W(RC_W), .RC_PREV(RC_PREV)) u_verdict (
    .pred(pred_q), .kind(kind), .code(code), .flags(flags),
    .flags_we(flags_we), .qual(qual)
  );

  trk_lock_table #(.SLOTS(SLOTS)) u_locks (
    .clk(clk), .rst_n(rst_n),
    .set_en(take_lock), .set_slot(req_addr[PAGE_SHIFT +: SLOT_W]),
    .clr_en(busy_q),    .clr_slot(addr_q[PAGE_SHIFT +: SLOT_W]),
    .lock_q(lock_o)
  );

  assign res_valid       = busy_q;
  assign res_kind        = busy_q ? kind : '0;
  assign res_code        = busy_q ? code : '0;
  assign res_flags       = busy_q ? flags : '0;
  assign res_flags_we    = busy_q && flags_we;
  assign res_fault_addr  = (busy_q && kind[KIND_PF]) ? addr_q : '0;
  assign res_exit_reason = (busy_q && kind[KIND_EXIT]) ? EXIT_REASON : '0;
  assign res_exit_qual   = (busy_q && kind[KIND_EXIT]) ? qual : QUAL_NONE;
  assign res_exit_gpa    = (busy_q && kind[KIND_EXIT]) ? ctx_q : '0;
  assign res_exit_gla    = '0;

  // R1
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_kind) == 1));
  // R13
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (lock_o == '0));
  // R12
  flags_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_flags_we |-> (res_kind[KIND_OK] || res_kind[KIND_SOFT]));
  // R10
  soft_zf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_kind[KIND_SOFT] |-> (res_flags[FLAG_ZF] && res_code == RC_W'(RC_PREV)));
endmodule

// File: tb/trk_req_checker_bench.sv
module trk_req_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_leaf = 8'h0C;
  logic [1:0]  req_cpl = '0;
  logic [31:0] req_addr = '0;
  logic        st_in_region = 1'b0, st_map_valid = 1'b0;
  logic [2:0]  st_page_type = '0;
  logic [7:0]  st_track = '0;
  logic        st_facility_busy = 1'b0, st_guest = 1'b0, st_virt_ext = 1'b0;
  logic [31:0] st_context = '0;
  logic        res_valid, res_flags_we;
  logic [4:0]  res_kind;
  logic [7:0]  res_code, res_exit_reason;
  logic [5:0]  res_flags;
  logic [1:0]  res_exit_qual;
  logic [31:0] res_fault_addr, res_exit_gpa, res_exit_gla;
  logic [3:0]  lock_o;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  trk_req_checker u_trk_req_checker (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
    chk(res_valid == 1'b0, "R1", "reset valid", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lock_o == 4'd0, "R13", "reset lock", 64'(lock_o), 64'd0);

    // sweep of every check-input combination
    for (int v = 0; v < 512; v++) begin
      logic [4:0]  ek;
      logic [7:0]  ecode;
      logic [5:0]  eflags;
      logic        ewe;
      logic [1:0]  equal;
      logic [3:0]  elock;
      logic        b_cpl, b_mis, b_out, b_busy, b_gst, b_ext, b_inv, b_typ, b_trk;
      string       tag;
      b_cpl = v[0]; b_mis = v[1]; b_out = v[2]; b_busy = v[3]; b_gst = v[4];
      b_ext = v[5]; b_inv = v[6]; b_typ = v[7]; b_trk = v[8];
      req_leaf         = 8'h0C;
      req_cpl          = b_cpl ? 2'(1 + v % 3) : 2'd0;
      req_addr         = 32'h0040_0000 + (32'(v) << 12) +
                         (b_mis ? 32'((v * 37) % 4095 + 1) : 32'd0);
      st_in_region     = !b_out;
      st_facility_busy = b_busy;
      st_guest         = b_gst;
      st_virt_ext      = b_ext;
      st_map_valid     = !b_inv;
      st_page_type     = b_typ ? 3'(((v >> 2) % 7) + 2) % 8 == 1 ? 3'd0 : 3'(((v >> 2) % 7) + 2)
                               : 3'd1;
      st_track         = b_trk ? 8'(v % 255 + 1) : 8'd0;
      st_context       = 32'hC000_0000 ^ (32'(v) * 32'h0001_0101);
      // expected outcome from the requirements
      ek = '0; ecode = '0; eflags = '0; ewe = 1'b0; equal = 2'd0; elock = '0;
      if (b_cpl) begin ek[2] = 1; tag = "R3"; end
      else if (b_mis) begin ek[2] = 1; tag = "R4"; end
      else if (b_out) begin ek[3] = 1; tag = "R5"; end
      else if (b_busy && b_gst && b_ext) begin ek[4] = 1; equal = 2'd1; tag = "R6"; end
      else if (b_busy) begin ek[2] = 1; tag = "R7"; end
      else if (b_inv) begin ek[3] = 1; tag = "R8"; end
      else if (b_typ) begin ek[3] = 1; tag = "R9"; end
      else if (b_trk && b_gst && b_ext) begin ek[4] = 1; equal = 2'd2; tag = "R11"; end
      else if (b_trk) begin ek[1] = 1; ecode = 8'h21; eflags = 6'b001000; ewe = 1; tag = "R10"; end
      else begin ek[0] = 1; ewe = 1; tag = "R12"; end
      if (!b_cpl && !b_mis && !b_out && !b_busy) elock = 4'(1 << req_addr[13:12]);

      @(negedge clk);
      req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      chk(res_valid == 1'b1, "R1", "pulse", 64'(res_valid), 64'd1);
      chk(req_ready == 1'b0, "R1", "ready low", 64'(req_ready), 64'd0);
      chk(res_kind == ek, tag, "kind", 64'(res_kind), 64'(ek));
      chk(res_code == ecode, tag, "code", 64'(res_code), 64'(ecode));
      chk(res_flags == eflags, "R12", "flags", 64'(res_flags), 64'(eflags));
      chk(res_flags_we == ewe, "R12", "flags_we", 64'(res_flags_we), 64'(ewe));
      chk(res_fault_addr == (ek[3] ? req_addr : 32'd0), tag, "fault addr",
          64'(res_fault_addr), 64'(ek[3] ? req_addr : 32'd0));
      chk(res_exit_qual == equal, tag, "qual", 64'(res_exit_qual), 64'(equal));
      chk(res_exit_reason == (ek[4] ? 8'h3F : 8'h00), tag, "reason",
          64'(res_exit_reason), 64'(ek[4] ? 8'h3F : 8'h00));
      chk(res_exit_gpa == (ek[4] ? st_context : 32'd0), tag, "gpa",
          64'(res_exit_gpa), 64'(ek[4] ? st_context : 32'd0));
      chk(res_exit_gla == 32'd0, "R6", "gla", 64'(res_exit_gla), 64'd0);
      chk(lock_o == elock, "R13", "lock held", 64'(lock_o), 64'(elock));
      @(negedge clk);
      chk(res_valid == 1'b0, "R1", "pulse end", 64'(res_valid), 64'd0);
      chk(req_ready == 1'b1, "R1", "ready back", 64'(req_ready), 64'd1);
      chk(lock_o == 4'd0, "R13", "lock free", 64'(lock_o), 64'd0);
    end

    // foreign leaf codes are consumed silently
    for (int lf = 0; lf < 16; lf++) begin
      req_leaf = (lf == 12) ? 8'hFF : 8'(lf);
      req_cpl = 2'd0; req_addr = 32'h0010_3000; st_in_region = 1;
      st_facility_busy = 0; st_map_valid = 1; st_page_type = 3'd1; st_track = 0;
      @(negedge clk);
      req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      chk(res_valid == 1'b0, "R2", "no pulse", 64'(res_valid), 64'd0);
      chk(req_ready == 1'b1, "R2", "ready kept", 64'(req_ready), 64'd1);
      chk(lock_o == 4'd0, "R2", "no lock", 64'(lock_o), 64'd0);
    end

    // held valid: second request waits out the evaluation cycle
    req_leaf = 8'h0C;
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b1, "R1", "hold first", 64'(res_valid), 64'd1);
    @(negedge clk);
    chk(res_valid == 1'b0, "R1", "hold gap", 64'(res_valid), 64'd0);
    chk(req_ready == 1'b1, "R1", "hold ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk(res_valid == 1'b1, "R1", "hold second", 64'(res_valid), 64'd1);
    chk(res_kind == 5'b00001, "R12", "hold kind", 64'(res_kind), 64'd1);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule